// File: doc/BRIEF.md
# CAN Mailbox Transmit Control Registers

This block holds the per-mailbox transmit bookkeeping of a CAN controller with 32 message mailboxes. For each mailbox it keeps three flags: a transmit-pending flag that software raises to queue a frame, a cancel-request flag that asks the protocol engine to withdraw a queued frame, and an acknowledge flag that records a finished transmission. Software reaches the flags through a synchronous 16-bit register port. Each function occupies two halfword registers: the low one covers mailboxes 15 to 0 and the high one covers mailboxes 31 to 16.

The protocol engine reads the pending and cancel vectors directly. It reports back with one-cycle pulse vectors: one for a successful transmission and one for a completed cancellation. A direction input marks each mailbox as transmit-capable or receive. Mailbox 0 is always treated as receive-only, whatever that input says. Reads return data one cycle after the request. All flag updates take effect at the clock edge that ends the write or pulse cycle.

Top module: `can_txctl_regs`

## Requirements
- R1: After reset all pending, cancel and acknowledge flags are zero, pend_o and cancel_o are zero, and reg_rdata is zero.
- R2: A write of ones to the pending registers (offset 0 covers mailboxes 15..0 with bit n for mailbox n; offset 1 covers mailboxes 31..16 with bit n for mailbox 16+n) sets the pending flag of each such mailbox whose mbox_is_tx bit is 1 in that cycle. Bits written as zero, and mailboxes configured as receive, are left unchanged.
- R3: Mailbox 0 is receive-only. Pending bit 0 and cancel bit 0 always read as zero, and pend_o[0] and cancel_o[0] are always zero, even when mbox_is_tx[0] is 1 and a one is written to bit 0.
- R4: A write of ones to the cancel registers (offset 2 covers mailboxes 15..0; offset 3 covers mailboxes 31..16; same bit order as R2) sets the cancel flag of a mailbox only if that mailbox is pending and configured as transmit in that cycle. Otherwise the write is ignored. Writing zero never clears a cancel flag.
- R5: A pulse on eng_cancel_done for a mailbox clears both its pending and its cancel flag at the same clock edge.
- R6: A pulse on eng_tx_done for a mailbox clears its pending and cancel flags and sets its acknowledge flag at the same clock edge.
- R7: Writing a one to an acknowledge register bit (offset 4 covers mailboxes 15..0; offset 5 covers mailboxes 31..16; same bit order as R2) clears that flag. Writing a zero leaves it unchanged. An acknowledge flag clears by no other means.
- R8: If eng_tx_done and a write-one-to-clear hit the same acknowledge flag in the same cycle, the flag ends up set.
- R9: A read request (reg_en=1, reg_we=0) returns the addressed register on reg_rdata in the next cycle, showing the flag state of the request cycle. Offsets 6 and 7 read as zero. reg_rdata is zero in any cycle after one that had no read request.
- R10: pend_o and cancel_o always show the current pending and cancel flags of all 32 mailboxes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the request |
| mbox_is_tx | input | 32 | Per-mailbox direction, 1 for transmit |
| eng_tx_done | input | 32 | Per-mailbox pulse on transmit success |
| eng_cancel_done | input | 32 | Per-mailbox pulse on cancellation complete |
| pend_o | output | 32 | Pending flags to the engine |
| cancel_o | output | 32 | Cancel flags to the engine |

## Verification
The assertions assume that the engine behaves properly. It pulses eng_tx_done only for mailboxes that are pending. It pulses eng_cancel_done only for mailboxes whose cancel flag is set. It never pulses both for the same mailbox in one cycle. The bench follows these rules by building every engine pulse from its model of the flags: it masks random bits with the modelled pending vector, then with the modelled cancel vector, and removes any overlap. Register writes, direction changes and data values are otherwise left free, including writes to mailbox 0 and to receive mailboxes.

// File: rtl/can_txctl_pkg.sv
// Shared sizes, register offsets and the flag record for the CAN
// mailbox transmit control register bank.
package can_txctl_pkg;
    localparam int NUM_MBOX  = 32;
    localparam int REG_W     = 16;
    localparam int NUM_HW    = NUM_MBOX / REG_W;
    localparam int NUM_REGS  = 3 * NUM_HW;
    localparam int ADDR_W    = $clog2(NUM_REGS);
    localparam int PEND_BASE = 0;
    localparam int CANC_BASE = NUM_HW;
    localparam int ACK_BASE  = 2 * NUM_HW;
    // Mailboxes that can never transmit (mailbox 0 only).
    localparam logic [NUM_MBOX-1:0] RX_ONLY_MASK = NUM_MBOX'(1);

    typedef struct packed {
        logic pend;
        logic canc;
        logic ack;
    } mbox_flags_t;
endpackage

// File: rtl/txctl_mbox_flags.sv
// Flag state of one mailbox: pending, cancel request, acknowledge.
// Assumes tx_done and canc_done come only for a pending mailbox and
// never together. Engine completion has priority over software sets,
// and a transmit success beats a software clear of the acknowledge.
module txctl_mbox_flags
    import can_txctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_capable,
    input  logic        req_pend,
    input  logic        req_canc,
    input  logic        req_ack_clr,
    input  logic        tx_done,
    input  logic        canc_done,
    output mbox_flags_t flags
);
    mbox_flags_t flags_q;
    mbox_flags_t flags_d;
    logic        finished;

    // Next-state rules for the three flags.
    always_comb begin
        finished = tx_done | canc_done;
        flags_d  = flags_q;
        if (finished) begin
            flags_d.pend = 1'b0;
            flags_d.canc = 1'b0;
        end else begin
            if (req_pend && tx_capable)
                flags_d.pend = 1'b1;
            if (req_canc && tx_capable && flags_q.pend)
                flags_d.canc = 1'b1;
        end
        if (tx_done)
            flags_d.ack = 1'b1;
        else if (req_ack_clr)
            flags_d.ack = 1'b0;
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/txctl_wr_decode.sv
// Turns a register write into per-mailbox set and clear request masks.
// Each function spans NUM_HW consecutive halfword offsets, lowest
// mailboxes first.
module txctl_wr_decode
    import can_txctl_pkg::*;
(
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [NUM_MBOX-1:0] pend_set,
    output logic [NUM_MBOX-1:0] canc_set,
    output logic [NUM_MBOX-1:0] ack_clr
);
    logic wr;
    assign wr = reg_en & reg_we;

    for (genvar h = 0; h < NUM_HW; h++) begin : g_hw
        localparam logic [ADDR_W-1:0] P_OFF = ADDR_W'(PEND_BASE + h);
        localparam logic [ADDR_W-1:0] C_OFF = ADDR_W'(CANC_BASE + h);
        localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(ACK_BASE + h);
        assign pend_set[h*REG_W +: REG_W] = (wr && reg_addr == P_OFF) ? reg_wdata : '0;
        assign canc_set[h*REG_W +: REG_W] = (wr && reg_addr == C_OFF) ? reg_wdata : '0;
        assign ack_clr[h*REG_W +: REG_W]  = (wr && reg_addr == A_OFF) ? reg_wdata : '0;
    end
endmodule

// File: rtl/txctl_rd_mux.sv
// Registered read path: selects one halfword of the flag vectors and
// presents it one cycle later. Undefined offsets and idle cycles give
// zero.
module txctl_rd_mux
    import can_txctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NUM_MBOX-1:0] pend_v,
    input  logic [NUM_MBOX-1:0] canc_v,
    input  logic [NUM_MBOX-1:0] ack_v,
    output logic [REG_W-1:0]    reg_rdata
);
    logic [REG_W-1:0] word_sel;

    // Halfword selection by offset.
    always_comb begin
        word_sel = '0;
        for (int h = 0; h < NUM_HW; h++) begin
            if (reg_addr == ADDR_W'(PEND_BASE + h)) word_sel = pend_v[h*REG_W +: REG_W];
            if (reg_addr == ADDR_W'(CANC_BASE + h)) word_sel = canc_v[h*REG_W +: REG_W];
            if (reg_addr == ADDR_W'(ACK_BASE + h))  word_sel = ack_v[h*REG_W +: REG_W];
        end
    end

    // Read data register, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_en && !reg_we)
            reg_rdata <= word_sel;
        else
            reg_rdata <= '0;
    end
endmodule

// File: rtl/can_txctl_regs.sv
// Top of the CAN mailbox transmit control register bank. Decodes
// software writes, keeps one flag slice per mailbox and serves
// registered reads. Mailbox 0 is forced receive-only. Assumes the
// engine pulses completions only for mailboxes that are in flight.
module can_txctl_regs
    import can_txctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_MBOX-1:0] mbox_is_tx,
    input  logic [NUM_MBOX-1:0] eng_tx_done,
    input  logic [NUM_MBOX-1:0] eng_cancel_done,
    output logic [NUM_MBOX-1:0] pend_o,
    output logic [NUM_MBOX-1:0] cancel_o
);
    logic [NUM_MBOX-1:0] pend_set;
    logic [NUM_MBOX-1:0] canc_set;
    logic [NUM_MBOX-1:0] ack_clr;
    logic [NUM_MBOX-1:0] tx_capable;
    logic [NUM_MBOX-1:0] pend_v;
    logic [NUM_MBOX-1:0] canc_v;
    logic [NUM_MBOX-1:0] ack_v;
    mbox_flags_t         flags_a [NUM_MBOX];

    assign tx_capable = mbox_is_tx & ~RX_ONLY_MASK;

    txctl_wr_decode u_dec (
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend_set  (pend_set),
        .canc_set  (canc_set),
        .ack_clr   (ack_clr)
    );

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
        txctl_mbox_flags u_flags (
            .clk         (clk),
            .rst_n       (rst_n),
            .tx_capable  (tx_capable[m]),
            .req_pend    (pend_set[m]),
            .req_canc    (canc_set[m]),
            .req_ack_clr (ack_clr[m]),
            .tx_done     (eng_tx_done[m]),
            .canc_done   (eng_cancel_done[m]),
            .flags       (flags_a[m])
        );
        assign pend_v[m] = flags_a[m].pend;
        assign canc_v[m] = flags_a[m].canc;
        assign ack_v[m]  = flags_a[m].ack;
    end

    txctl_rd_mux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .pend_v    (pend_v),
        .canc_v    (canc_v),
        .ack_v     (ack_v),
        .reg_rdata (reg_rdata)
    );

    assign pend_o   = pend_v;
    assign cancel_o = canc_v;
endmodule

// File: rtl/can_txctl_chk.sv
// Property checker for can_txctl_regs, attached by bind. Assumes the
// engine completes only in-flight mailboxes and never both ways at once.
module can_txctl_chk
    import can_txctl_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_en,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [REG_W-1:0]    reg_wdata,
    input logic [REG_W-1:0]    reg_rdata,
    input logic [NUM_MBOX-1:0] mbox_is_tx,
    input logic [NUM_MBOX-1:0] eng_tx_done,
    input logic [NUM_MBOX-1:0] eng_cancel_done,
    input logic [NUM_MBOX-1:0] pend_o,
    input logic [NUM_MBOX-1:0] cancel_o,
    input logic [NUM_MBOX-1:0] ack_v
);
    logic [NUM_MBOX-1:0] ack_wr_mask;

    // Mailboxes that software asks to clear this cycle.
    always_comb begin
        ack_wr_mask = '0;
        for (int h = 0; h < NUM_HW; h++)
            if (reg_en && reg_we && reg_addr == ADDR_W'(ACK_BASE + h))
                ack_wr_mask[h*REG_W +: REG_W] = reg_wdata;
    end

    a_r2_pend_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~$past(pend_o) & ~$past(mbox_is_tx)) == '0);

    a_r3_mbox0_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[0] == 1'b0) && (cancel_o[0] == 1'b0));

    a_r4_cancel_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_o & ~$past(cancel_o) & ~($past(pend_o) & $past(mbox_is_tx))) == '0);

    a_r4_cancel_within_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_o & ~pend_o) == '0);

    a_r5_cancel_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_cancel_done) |=> (((pend_o | cancel_o) & $past(eng_cancel_done)) == '0));

    a_r6_tx_done_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_tx_done) |=> ((pend_o & $past(eng_tx_done)) == '0));

    a_r7_ack_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_v) & ~ack_v & ~$past(ack_wr_mask)) == '0);

    a_r8_ack_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_tx_done) |=> ((ack_v & $past(eng_tx_done)) == $past(eng_tx_done)));

    a_r9_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> (reg_rdata == '0));

    a_r9_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr >= ADDR_W'(NUM_REGS)) |=> (reg_rdata == '0));

    a_r9_pend_lo_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr == ADDR_W'(PEND_BASE))
        |=> (reg_rdata == $past(pend_o[REG_W-1:0])));
endmodule

bind can_txctl_regs can_txctl_chk chk_i (.*);

// File: tb/can_txctl_regs_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// checked against a flag model built from the requirements.
module can_txctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] mbox_is_tx = '0;
    logic [31:0] eng_tx_done = '0;
    logic [31:0] eng_cancel_done = '0;
    logic [31:0] pend_o;
    logic [31:0] cancel_o;

    logic [31:0] pm = '0, cm = '0, am = '0;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    can_txctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mbox_is_tx(mbox_is_tx), .eng_tx_done(eng_tx_done),
        .eng_cancel_done(eng_cancel_done), .pend_o(pend_o), .cancel_o(cancel_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [2:0] a);
        case (a)
            3'd0: return pm[15:0];
            3'd1: return pm[31:16];
            3'd2: return cm[15:0];
            3'd3: return cm[31:16];
            3'd4: return am[15:0];
            3'd5: return am[31:16];
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R4";
            3'd4, 3'd5: return "R7";
            default:    return "R9";
        endcase
    endfunction

    // One clock cycle of stimulus, entered just after a falling edge.
    task automatic cycle(input logic en, input logic we, input logic [2:0] a,
                         input logic [15:0] d, input logic [31:0] t, input logic [31:0] c);
        logic [31:0] pw, cw, aw, np, nc, na;
        reg_en = en; reg_we = we; reg_addr = a; reg_wdata = d;
        eng_tx_done = t; eng_cancel_done = c;
        pw = '0; cw = '0; aw = '0;
        if (en && we) begin
            case (a)
                3'd0: pw[15:0] = d;
                3'd1: pw[31:16] = d;
                3'd2: cw[15:0] = d;
                3'd3: cw[31:16] = d;
                3'd4: aw[15:0] = d;
                3'd5: aw[31:16] = d;
                default: ;
            endcase
        end
        for (int i = 0; i < 32; i++) begin
            bit cap;
            cap = mbox_is_tx[i] && (i != 0);
            if (t[i] || c[i]) begin
                np[i] = 1'b0; nc[i] = 1'b0;
            end else begin
                np[i] = pm[i] | (pw[i] & cap);
                nc[i] = cm[i] | (cw[i] & cap & pm[i]);
            end
            na[i] = t[i] ? 1'b1 : (am[i] & ~aw[i]);
        end
        @(negedge clk);
        pm = np; cm = nc; am = na;
        reg_en = 1'b0; reg_we = 1'b0; eng_tx_done = '0; eng_cancel_done = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cycle(1'b1, 1'b1, a, d, '0, '0);
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag);
        cycle(1'b1, 1'b0, a, 16'h0, '0, '0);
        check(tag, {16'h0, reg_rdata}, {16'h0, exp_word(a)});
    endtask

    task automatic rd_lit(input logic [2:0] a, input string tag, input logic [15:0] exp);
        cycle(1'b1, 1'b0, a, 16'h0, '0, '0);
        check(tag, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", pend_o, 32'h0);
        check("R1", cancel_o, 32'h0);
        check("R1", {16'h0, reg_rdata}, 32'h0);
        for (int a = 0; a < 6; a++) rd_lit(3'(a), "R1", 16'h0);

        // R3: mailbox 0 refuses pending even when marked transmit
        mbox_is_tx = 32'hFFFF_FFFF;
        wr(3'd0, 16'hFFFF);
        rd_lit(3'd0, "R3", 16'hFFFE);
        check("R3", {31'h0, pend_o[0]}, 32'h0);
        wr(3'd2, 16'h0001);
        rd_lit(3'd2, "R3", 16'h0000);

        // R2: receive mailbox 20 ignores a pending write
        mbox_is_tx = 32'hFFEF_FFFF;
        wr(3'd1, 16'h0010);
        rd_lit(3'd1, "R2", 16'h0000);
        // R4: cancel of a non-pending mailbox is ignored
        wr(3'd3, 16'h0010);
        rd_lit(3'd3, "R4", 16'h0000);

        // R4: cancel of pending mailbox 5 accepted, zero write cannot withdraw
        wr(3'd2, 16'h0020);
        check("R4", cancel_o, 32'h0000_0020);
        wr(3'd2, 16'h0000);
        check("R4", cancel_o, 32'h0000_0020);

        // R5: cancellation completion clears pending and cancel together
        cycle(1'b0, 1'b0, 3'd0, 16'h0, 32'h0, 32'h0000_0020);
        check("R5", pend_o & 32'h20, 32'h0);
        check("R5", cancel_o, 32'h0);

        // R6: transmit success on mailbox 7
        cycle(1'b0, 1'b0, 3'd0, 16'h0, 32'h0000_0080, 32'h0);
        check("R6", pend_o & 32'h80, 32'h0);
        rd_lit(3'd4, "R6", 16'h0080);

        // R7: zero write keeps, one write clears
        wr(3'd4, 16'h0000);
        rd_lit(3'd4, "R7", 16'h0080);
        wr(3'd4, 16'h0080);
        rd_lit(3'd4, "R7", 16'h0000);

        // R8: set beats clear on mailbox 9
        cycle(1'b1, 1'b1, 3'd4, 16'h0200, 32'h0000_0200, 32'h0);
        rd_lit(3'd4, "R8", 16'h0200);

        // R9: undefined offsets and idle cycles read zero
        rd_lit(3'd6, "R9", 16'h0);
        rd_lit(3'd7, "R9", 16'h0);
        rd_chk(3'd0, "R9");
        cycle(1'b0, 1'b0, 3'd0, 16'h0, '0, '0);
        check("R9", {16'h0, reg_rdata}, 32'h0);

        // Random traffic
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [31:0] t, c;
            if ($urandom % 16 == 0) mbox_is_tx = $urandom | $urandom;
            op = $urandom % 6;
            t = pm & $urandom & $urandom;
            c = cm & ~t & $urandom;
            case (op)
                0: wr(3'($urandom % 2), 16'($urandom));
                1: wr(3'(2 + $urandom % 2), 16'($urandom));
                2: wr(3'(4 + $urandom % 2), 16'($urandom));
                3: cycle(1'b0, 1'b0, 3'd0, 16'h0, t, c);
                4: cycle(1'b1, 1'b1, 3'(4 + $urandom % 2), 16'($urandom), t, c);
                default: cycle(1'b1, 1'b1, 3'(2 + $urandom % 2), 16'($urandom), t, c);
            endcase
            check("R10", pend_o, pm);
            check("R10", cancel_o, cm);
            begin
                logic [2:0] ra;
                ra = 3'($urandom % 8);
                rd_chk(ra, tag_of(ra));
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule